// File: doc/BRIEF.md
# Indexed-Port BCD Real-Time Clock

This block is a calendar clock in a 128-byte register space. Software reaches it through two byte ports. A write to the index port selects one of the 128 locations, and a following read or write of the data port reaches that location. The block counts seconds, minutes, hours, weekday, day of month, month and a two-digit year, all in packed BCD. The count advances once for every `TICKS_PER_SEC` pulses of a reference tick enable, which is nominally 32.768 kHz. The register space also holds three alarm bytes, four control and status bytes, and general-purpose RAM.

The block is built around an update state machine. Its states are `ST_COUNT`, `ST_WARN`, `ST_STEP`, `ST_DONE` and `ST_FROZEN`.
- From `ST_COUNT`, the `warn` transition is taken `UIP_TICKS` ticks before the end of each second.
- `ST_WARN` raises the update-in-progress flag. Its `second` transition leads to `ST_STEP`, which advances the calendar for one cycle.
- From `ST_STEP`, the `finish` transition leads to `ST_DONE`. That state posts the update-ended and alarm events, and its `resume` transition returns to `ST_COUNT`.
- The `freeze` transition is taken from any waiting state when the inhibit bit is set, and leads to `ST_FROZEN`. The `thaw` transition leaves `ST_FROZEN` for `ST_WARN` when the release lands inside the warning window, and for `ST_COUNT` otherwise.
- A dropped oscillator (`halt`) returns `ST_WARN` to `ST_COUNT`.

Interrupt events are latched in the flag register and cleared when that register is read. Each flag can be enabled separately onto the `irq` pin.

Top module: `idx_rtc`

## Requirements
- R1: A write to port 0 (`bus_sel`=0) latches `bus_wdata[6:0]` as the index. A read of port 0 returns the index with bit 7 at 0. A read or write of port 1 reaches the indexed register. Read data appears on `bus_rdata` the cycle after the `bus_rd` strobe and holds until the next strobe.
- R2: Locations 0x0E to 0x7F are RAM and return the last value written to them.
- R3: Control A bit 7 is the read-only update-in-progress flag. It rises `UIP_TICKS` ticks before each once-per-second update and falls once the calendar has advanced.
- R4: While control B bit 7 is 1, the time fields never advance, the update flag reads 0, and the time fields at 0x00, 0x02, 0x04 and 0x06 to 0x09 accept host writes.
- R5: The time advances once per `TICKS_PER_SEC` ticks only while control A bits 6:4 equal 010. Any other value stops the prescaler and the periodic divider.
- R6: The reset state is: A = 0x26, B = 0x02, flags (C) = 0x00, D = 0x80, time 00:00:00, weekday 01, date 01, month 01, year 00. Writes to C and D have no effect, and A bit 7 ignores writes.
- R7: Seconds and minutes count 00 to 59 in BCD and hours count 00 to 23. Each carry ripples upward. The weekday wraps from 07 to 01 at midnight.
- R8: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. Month 02 ends at 29 when the BCD year is a multiple of four, and at 28 otherwise.
- R9: Month 12 wraps to 01 and year 99 wraps to 00.
- R10: Every update sets flag bit 4. Bit 5 is set at an update whose new seconds, minutes and hours equal the alarm bytes at 0x01, 0x03 and 0x05.
- R11: Flag bit 6 is set once every 2^k ticks. k is 7 for A[3:0] = 1, 8 for A[3:0] = 2, and A[3:0] minus 1 for A[3:0] = 3 to 15. A value of 0 disables it, and 6 gives a period of 32 ticks.
- R12: Reading C (index 0x0C) returns {IRQ, PF, AF, UF, 0000} and clears bits 6:4. IRQ is the OR of each flag ANDed with its enable in B bits 6:4, in the same order, and the `irq` pin equals IRQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle reference tick enable |
| bus_sel | input | 1 | Port select: 0 index, 1 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest cases to reach from the ports are the calendar rollovers: month ends, leap February, year 99 and the weekday wrap. Each of them needs a precise time loaded just before a second boundary. The bench gets there by setting the inhibit bit and loading the fields while the clock is frozen. It then releases the clock and polls the update flag until it has risen and fallen, so the read-back always follows exactly one update. The alarm and flag checks reuse the same sequence, so that the flag register is sampled right after a known update.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int IDX_W = 7;

    localparam logic [IDX_W-1:0] IDX_SEC     = 7'h00;
    localparam logic [IDX_W-1:0] IDX_SEC_ALM = 7'h01;
    localparam logic [IDX_W-1:0] IDX_MIN     = 7'h02;
    localparam logic [IDX_W-1:0] IDX_MIN_ALM = 7'h03;
    localparam logic [IDX_W-1:0] IDX_HOUR    = 7'h04;
    localparam logic [IDX_W-1:0] IDX_HR_ALM  = 7'h05;
    localparam logic [IDX_W-1:0] IDX_WDAY    = 7'h06;
    localparam logic [IDX_W-1:0] IDX_DATE    = 7'h07;
    localparam logic [IDX_W-1:0] IDX_MONTH   = 7'h08;
    localparam logic [IDX_W-1:0] IDX_YEAR    = 7'h09;
    localparam logic [IDX_W-1:0] IDX_CTL_A   = 7'h0A;
    localparam logic [IDX_W-1:0] IDX_CTL_B   = 7'h0B;
    localparam logic [IDX_W-1:0] IDX_FLAGS   = 7'h0C;
    localparam logic [IDX_W-1:0] IDX_VALID   = 7'h0D;
    localparam logic [IDX_W-1:0] RAM_BASE    = 7'h0E;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    typedef enum logic [2:0] {
        ST_COUNT,
        ST_WARN,
        ST_STEP,
        ST_DONE,
        ST_FROZEN
    } upd_state_t;

    // One BCD step, returning to 'first' once 'last' is reached
    function automatic logic [7:0] bcd_incr(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v == last)
            return first;
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_nvram.sv
module rtc_nvram #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       osc_on,
    input  logic [3:0] rate_sel,
    output logic       warn_hit,
    output logic       sec_hit,
    output logic       in_window,
    output logic       pf_hit
);

    localparam int CNT_W   = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int DIV_W   = 15;
    localparam int LAST    = TICKS_PER_SEC - 1;
    localparam int WARN_AT = TICKS_PER_SEC - 1 - UIP_TICKS;
    localparam int WIN_LO  = TICKS_PER_SEC - UIP_TICKS;

    logic [CNT_W-1:0] sec_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [3:0]       k;
    logic [DIV_W-1:0] mask;
    logic             run_tick;

    assign run_tick = ref_tick && osc_on;

    always_ff @(posedge clk) begin
        if (!rst_n || !osc_on)
            sec_cnt <= '0;
        else if (ref_tick) begin
            if (sec_cnt == CNT_W'(LAST))
                sec_cnt <= '0;
            else
                sec_cnt <= sec_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !osc_on)
            div_cnt <= '0;
        else if (ref_tick)
            div_cnt <= div_cnt + 1'b1;
    end

    always_comb begin
        unique case (rate_sel)
            4'd0:    k = 4'd0;
            4'd1:    k = 4'd7;
            4'd2:    k = 4'd8;
            default: k = rate_sel - 4'd1;
        endcase
        mask = (DIV_W'(1) << k) - DIV_W'(1);
    end

    assign warn_hit  = run_tick && (sec_cnt == CNT_W'(WARN_AT));
    assign sec_hit   = run_tick && (sec_cnt == CNT_W'(LAST));
    assign in_window = osc_on && (sec_cnt >= CNT_W'(WIN_LO));
    assign pf_hit    = run_tick && (rate_sel != 4'd0) && ((div_cnt & mask) == mask);

endmodule

// File: rtl/rtc_update_fsm.sv
module rtc_update_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_on,
    input  logic inhibit,
    input  logic warn_hit,
    input  logic sec_hit,
    input  logic in_window,
    output logic uip,
    output logic step,
    output logic upd_done
);

    upd_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_COUNT;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: begin
                if (inhibit)       state_d = ST_FROZEN;   // freeze
                else if (warn_hit) state_d = ST_WARN;     // warn
            end
            ST_WARN: begin
                if (inhibit)      state_d = ST_FROZEN;    // freeze
                else if (!osc_on) state_d = ST_COUNT;     // halt
                else if (sec_hit) state_d = ST_STEP;      // second
            end
            ST_STEP: begin
                state_d = inhibit ? ST_FROZEN : ST_DONE;  // finish
            end
            ST_DONE: begin
                state_d = inhibit ? ST_FROZEN : ST_COUNT; // resume
            end
            ST_FROZEN: begin
                if (!inhibit)                             // thaw
                    state_d = (in_window && !sec_hit) ? ST_WARN : ST_COUNT;
            end
        endcase
    end

    always_comb begin
        uip      = 1'b0;
        step     = 1'b0;
        upd_done = 1'b0;
        unique case (state_q)
            ST_WARN:   uip = !inhibit;
            ST_STEP: begin
                uip  = !inhibit;
                step = !inhibit;
            end
            ST_DONE:   upd_done = 1'b1;
            ST_COUNT, ST_FROZEN: ;
        endcase
    end

    // R3
    uip_before_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> $past(uip));

    // R10
    done_follows_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> $past(step));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    output rtc_time_t        now
);

    rtc_time_t  nxt;
    logic       leap;
    logic [7:0] date_last;
    logic       sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap;

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic lp);
        case (m)
            8'h02:                      return lp ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // A BCD year is a multiple of four when its units digit fits the tens parity
    assign leap       = now.year[4] ? (now.year[1:0] == 2'b10) : (now.year[1:0] == 2'b00);
    assign date_last  = month_last(now.month, leap);
    assign sec_wrap   = (now.sec == 8'h59);
    assign min_wrap   = (now.min == 8'h59);
    assign hour_wrap  = (now.hour == 8'h23);
    assign date_wrap  = (now.date == date_last);
    assign month_wrap = (now.month == 8'h12);

    always_comb begin
        nxt     = now;
        nxt.sec = bcd_incr(now.sec, 8'h59, 8'h00);
        if (sec_wrap) begin
            nxt.min = bcd_incr(now.min, 8'h59, 8'h00);
            if (min_wrap) begin
                nxt.hour = bcd_incr(now.hour, 8'h23, 8'h00);
                if (hour_wrap) begin
                    nxt.wday = bcd_incr(now.wday, 8'h07, 8'h01);
                    nxt.date = bcd_incr(now.date, date_last, 8'h01);
                    if (date_wrap) begin
                        nxt.month = bcd_incr(now.month, 8'h12, 8'h01);
                        if (month_wrap)
                            nxt.year = bcd_incr(now.year, 8'h99, 8'h00);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= '{year: 8'h00, month: 8'h01, date: 8'h01, wday: 8'h01,
                     hour: 8'h00, min: 8'h00, sec: 8'h00};
        end else begin
            if (step)
                now <= nxt;
            if (wr_en) begin
                case (wr_idx)
                    IDX_SEC:   now.sec   <= wr_data;
                    IDX_MIN:   now.min   <= wr_data;
                    IDX_HOUR:  now.hour  <= wr_data;
                    IDX_WDAY:  now.wday  <= wr_data;
                    IDX_DATE:  now.date  <= wr_data;
                    IDX_MONTH: now.month <= wr_data;
                    IDX_YEAR:  now.year  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // R7
    step_moves_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(wr_en && wr_idx == IDX_SEC)) |=> (now.sec != $past(now.sec)));

endmodule

// File: rtl/idx_rtc.sv
module idx_rtc
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int UIP_TICKS     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);

    localparam int RAM_DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] idx_q;
    logic [6:0]       ctl_a_q;
    logic [7:0]       ctl_b_q;
    logic [7:0]       alm_sec_q, alm_min_q, alm_hour_q;
    logic [2:0]       flags_q;         // {periodic, alarm, update-ended}
    logic [7:0]       rdata_q;
    logic [7:0]       reg_val;
    logic [7:0]       ram_rd;
    rtc_time_t        now;

    logic host_wr, idx_wr, time_wr, ram_wr, flags_rd;
    logic osc_on, inhibit;
    logic warn_hit, sec_hit, in_window, pf_hit;
    logic uip, step, upd_done;
    logic alarm_match, af_hit;
    logic irqf;

    assign host_wr  = bus_wr && bus_sel;
    assign idx_wr   = bus_wr && !bus_sel;
    assign time_wr  = host_wr && (idx_q == IDX_SEC || idx_q == IDX_MIN || idx_q == IDX_HOUR ||
                                  (idx_q >= IDX_WDAY && idx_q <= IDX_YEAR));
    assign ram_wr   = host_wr && (idx_q >= RAM_BASE);
    assign flags_rd = bus_rd && bus_sel && (idx_q == IDX_FLAGS);
    assign osc_on   = (ctl_a_q[6:4] == 3'b010);
    assign inhibit  = ctl_b_q[7];

    rtc_timebase #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UIP_TICKS    (UIP_TICKS)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .osc_on   (osc_on),
        .rate_sel (ctl_a_q[3:0]),
        .warn_hit (warn_hit),
        .sec_hit  (sec_hit),
        .in_window(in_window),
        .pf_hit   (pf_hit)
    );

    rtc_update_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_on   (osc_on),
        .inhibit  (inhibit),
        .warn_hit (warn_hit),
        .sec_hit  (sec_hit),
        .in_window(in_window),
        .uip      (uip),
        .step     (step),
        .upd_done (upd_done)
    );

    rtc_calendar u_calendar (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .wr_en  (host_wr),
        .wr_idx (idx_q),
        .wr_data(bus_wdata),
        .now    (now)
    );

    rtc_nvram #(
        .DEPTH(RAM_DEPTH)
    ) u_ram (
        .clk  (clk),
        .we   (ram_wr),
        .addr (idx_q),
        .wdata(bus_wdata),
        .rdata(ram_rd)
    );

    // Index latch and control/alarm registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            ctl_a_q    <= 7'h26;
            ctl_b_q    <= 8'h02;
            alm_sec_q  <= 8'h00;
            alm_min_q  <= 8'h00;
            alm_hour_q <= 8'h00;
        end else begin
            if (idx_wr)
                idx_q <= bus_wdata[IDX_W-1:0];
            if (host_wr) begin
                case (idx_q)
                    IDX_CTL_A:   ctl_a_q    <= bus_wdata[6:0];
                    IDX_CTL_B:   ctl_b_q    <= bus_wdata;
                    IDX_SEC_ALM: alm_sec_q  <= bus_wdata;
                    IDX_MIN_ALM: alm_min_q  <= bus_wdata;
                    IDX_HR_ALM:  alm_hour_q <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Event flags: a new event in the read cycle survives the clear
    assign alarm_match = (now.sec == alm_sec_q) && (now.min == alm_min_q) &&
                         (now.hour == alm_hour_q);
    assign af_hit      = upd_done && alarm_match;

    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= (flags_rd ? 3'b000 : flags_q) | {pf_hit, af_hit, upd_done};
    end

    assign irqf = |(flags_q & ctl_b_q[6:4]);
    assign irq  = irqf;

    always_comb begin
        case (idx_q)
            IDX_SEC:     reg_val = now.sec;
            IDX_SEC_ALM: reg_val = alm_sec_q;
            IDX_MIN:     reg_val = now.min;
            IDX_MIN_ALM: reg_val = alm_min_q;
            IDX_HOUR:    reg_val = now.hour;
            IDX_HR_ALM:  reg_val = alm_hour_q;
            IDX_WDAY:    reg_val = now.wday;
            IDX_DATE:    reg_val = now.date;
            IDX_MONTH:   reg_val = now.month;
            IDX_YEAR:    reg_val = now.year;
            IDX_CTL_A:   reg_val = {uip, ctl_a_q};
            IDX_CTL_B:   reg_val = ctl_b_q;
            IDX_FLAGS:   reg_val = {irqf, flags_q, 4'b0000};
            IDX_VALID:   reg_val = 8'h80;
            default:     reg_val = ram_rd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= bus_sel ? reg_val : {1'b0, idx_q};
    end

    assign bus_rdata = rdata_q;

    // R4
    frozen_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !time_wr) |=> $stable(now));

    // R10
    uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> flags_q[0]);

    // R10
    af_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && alarm_match) |=> flags_q[1]);

    // R12
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && !pf_hit && !af_hit && !upd_done) |=> (flags_q == 3'b000));

endmodule

// File: tb/idx_rtc_test.sv
module idx_rtc_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    idx_rtc #(.TICKS_PER_SEC(64), .UIP_TICKS(8)) uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic port_wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic port_rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        port_wr(1'b0, idx);
        port_wr(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
        port_wr(1'b0, idx);
        port_rd(1'b1, d);
    endtask

    task automatic wait_update(input string req);
        logic [7:0] d;
        bit seen_hi = 0, seen_lo = 0;
        port_wr(1'b0, 8'h0A);
        for (int n = 0; n < 400; n++) begin
            port_rd(1'b1, d);
            if (d[7]) begin seen_hi = 1; break; end
        end
        if (seen_hi) begin
            for (int n = 0; n < 40; n++) begin
                port_rd(1'b1, d);
                if (!d[7]) begin seen_lo = 1; break; end
            end
        end
        chk(req, {6'd0, seen_hi, seen_lo}, 8'h03);
    endtask

    task automatic load_time(input logic [7:0] y, mo, dt, wd, h, mi, s);
        reg_wr(8'h0B, 8'h82);
        reg_wr(8'h09, y);  reg_wr(8'h08, mo); reg_wr(8'h07, dt);
        reg_wr(8'h06, wd); reg_wr(8'h04, h);  reg_wr(8'h02, mi);
        reg_wr(8'h00, s);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        reg_rd(8'h0A, d); chk("R6 ctl A", d, 8'h26);
        reg_rd(8'h0B, d); chk("R6 ctl B", d, 8'h02);
        reg_rd(8'h0C, d); chk("R6 flags", d, 8'h00);
        reg_rd(8'h0D, d); chk("R6 valid", d, 8'h80);
        reg_rd(8'h00, d); chk("R6 sec", d, 8'h00);
        reg_rd(8'h06, d); chk("R6 wday", d, 8'h01);
        reg_rd(8'h08, d); chk("R6 month", d, 8'h01);
    endtask

    task automatic t_ports_ram;
        logic [7:0] d;
        port_wr(1'b0, 8'hAB);
        port_rd(1'b0, d); chk("R1 index readback", d, 8'h2B);
        reg_wr(8'h20, 8'hA5);
        reg_wr(8'h7F, 8'h3C);
        reg_wr(8'h0E, 8'h5A);
        reg_rd(8'h20, d); chk("R2 ram 0x20", d, 8'hA5);
        reg_rd(8'h7F, d); chk("R2 ram 0x7F", d, 8'h3C);
        reg_rd(8'h0E, d); chk("R2 ram 0x0E", d, 8'h5A);
        repeat (3) @(negedge clk);
        chk("R1 rdata holds", bus_rdata, 8'h5A);
    endtask

    task automatic t_readonly;
        logic [7:0] d;
        reg_wr(8'h0D, 8'h00);
        reg_rd(8'h0D, d); chk("R6 D write ignored", d, 8'h80);
        reg_wr(8'h0A, 8'hA6);
        reg_rd(8'h0A, d); chk("R6 A low bits", d & 8'h7F, 8'h26);
    endtask

    task automatic t_inhibit;
        logic [7:0] d;
        bit uip_seen = 0;
        load_time(8'h24, 8'h06, 8'h10, 8'h02, 8'h08, 8'h15, 8'h30);
        port_wr(1'b0, 8'h0A);
        for (int n = 0; n < 120; n++) begin
            port_rd(1'b1, d);
            if (d[7]) uip_seen = 1;
        end
        chk("R4 no UIP while inhibited", {7'd0, uip_seen}, 8'h00);
        reg_rd(8'h00, d); chk("R4 sec frozen", d, 8'h30);
        reg_rd(8'h02, d); chk("R4 min written", d, 8'h15);
        reg_wr(8'h0B, 8'h02);
        wait_update("R3 UIP pulse after release");
        reg_rd(8'h00, d); chk("R3 sec advanced once", d, 8'h31);
    endtask

    task automatic t_osc_stop;
        logic [7:0] d;
        load_time(8'h24, 8'h06, 8'h10, 8'h02, 8'h08, 8'h15, 8'h10);
        reg_wr(8'h0A, 8'h00);
        reg_wr(8'h0B, 8'h02);
        repeat (300) @(negedge clk);
        reg_rd(8'h00, d); chk("R5 stopped divider", d, 8'h10);
        reg_wr(8'h0A, 8'h26);
        wait_update("R5 restart update");
        reg_rd(8'h00, d); chk("R5 sec after restart", d, 8'h11);
    endtask

    task automatic t_roll(input string req,
                          input logic [7:0] y, mo, dt, wd, h, mi, s,
                          input logic [7:0] ey, emo, edt, ewd, eh, emi, es);
        logic [7:0] d;
        load_time(y, mo, dt, wd, h, mi, s);
        reg_wr(8'h0B, 8'h02);
        wait_update(req);
        reg_rd(8'h00, d); chk({req, " sec"}, d, es);
        reg_rd(8'h02, d); chk({req, " min"}, d, emi);
        reg_rd(8'h04, d); chk({req, " hour"}, d, eh);
        reg_rd(8'h06, d); chk({req, " wday"}, d, ewd);
        reg_rd(8'h07, d); chk({req, " date"}, d, edt);
        reg_rd(8'h08, d); chk({req, " month"}, d, emo);
        reg_rd(8'h09, d); chk({req, " year"}, d, ey);
    endtask

    task automatic t_alarm(input logic [7:0] alm_s, input logic [7:0] exp_c, input logic exp_irq);
        logic [7:0] d;
        load_time(8'h24, 8'h03, 8'h05, 8'h03, 8'h12, 8'h30, 8'h04);
        reg_wr(8'h01, alm_s);
        reg_wr(8'h03, 8'h30);
        reg_wr(8'h05, 8'h12);
        reg_wr(8'h0A, 8'h20);
        reg_rd(8'h0C, d);
        reg_wr(8'h0B, 8'h22);
        wait_update("R10 alarm update");
        chk("R12 irq pin after update", {7'd0, irq}, {7'd0, exp_irq});
        reg_rd(8'h0C, d); chk("R10 flags after update", d, exp_c);
        reg_rd(8'h0C, d); chk("R12 flags cleared by read", d, 8'h00);
        chk("R12 irq pin after clear", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_periodic;
        logic [7:0] d;
        reg_wr(8'h0B, 8'h42);
        reg_wr(8'h0A, 8'h23);
        reg_rd(8'h0C, d);
        repeat (12) @(negedge clk);
        chk("R11 irq at rate 3", {7'd0, irq}, 8'h01);
        reg_rd(8'h0C, d); chk("R11 PF and IRQ bits", d & 8'hC0, 8'hC0);
        reg_wr(8'h0A, 8'h20);
        reg_rd(8'h0C, d);
        repeat (80) @(negedge clk);
        chk("R11 rate 0 silent", {7'd0, irq}, 8'h00);
        reg_wr(8'h0A, 8'h26);
        reg_rd(8'h0C, d);
        repeat (40) @(negedge clk);
        chk("R11 irq at rate 6", {7'd0, irq}, 8'h01);
        reg_wr(8'h0B, 8'h02);
        reg_rd(8'h0C, d);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ports_ram();
        t_readonly();
        t_inhibit();
        t_osc_stop();
        t_roll("R7 R8 leap Feb and weekday wrap",
               8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59,
               8'h24, 8'h02, 8'h29, 8'h01, 8'h00, 8'h00, 8'h00);
        t_roll("R8 plain Feb",
               8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59,
               8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00);
        t_roll("R8 30-day month",
               8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59,
               8'h24, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00);
        t_roll("R9 year wrap",
               8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59,
               8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
        t_roll("R7 digit carry",
               8'h24, 8'h07, 8'h15, 8'h04, 8'h09, 8'h59, 8'h59,
               8'h24, 8'h07, 8'h15, 8'h04, 8'h10, 8'h00, 8'h00);
        t_alarm(8'h05, 8'hB0, 1'b1);
        t_alarm(8'h09, 8'h10, 1'b0);
        t_periodic();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule